// File: doc/BRIEF.md
# Floating-Point Context Frame Save/Restore Controller

This block carries out the two context-switch operations of a floating-point unit: dumping its internal state frame to memory and reloading it. On a save it emits either a single zero longword, which marks an empty frame, or a seven-longword idle frame. It then hands back the updated address-register value for postincrement or predecrement addressing. On a restore it fetches the frame's first longword. An empty frame returns the unit to its power-on state by clearing the control registers and filling the data-register file with not-a-number patterns. Any other frame is skipped by a length decoded from its format byte.

A single-bit "fresh" flag records that the unit has not run anything since its last reset or empty-frame restore. While the flag is set, a save writes the short empty frame. Issuing any arithmetic or move operation to the unit clears the flag.

Commands enter on a valid/ready handshake: `cmd_ready` is high only while the controller is idle, and a command is taken on a clock edge with both high. Memory requests leave on a valid/ready handshake as well. Once `mem_req_valid` is raised, the request and its address, write flag and data hold steady until a clock edge sees `mem_req_ready` high. Read data returns on `mem_rvalid` with no back-pressure. Each command ends with a one-cycle `done_valid` pulse that carries the new address-register value.

Top module: `fsr_ctrl`

## Requirements
- R1: After reset, `fresh_flag` is 1, `cmd_ready` is 1, and `mem_req_valid`, `done_valid`, `rf_we` and `ctl_clr` are 0.
- R2: A save (`cmd_restore`=0) issued while `fresh_flag` is 1 performs exactly one write of 32'h0. With postincrement (mode 3) the write goes to A and the result is A+4. With predecrement (mode 4) the write goes to A-4 and the result is A-4.
- R3: A save issued while `fresh_flag` is 0 performs seven writes at ascending addresses base, base+4 … base+24. Their data is 32'h1F180000, then five 32'h0 words, then 32'h70000000. Postincrement uses base A and returns A+28. Predecrement uses base A-28 and returns A-28.
- R4: A save leaves `fresh_flag` unchanged.
- R5: A restore (`cmd_restore`=1) performs exactly one read, at address A, and no write. The frame is empty when bits 31:24 of the returned word are zero.
- R6: An empty-frame restore pulses `ctl_clr` for one cycle, together with the first of NREG consecutive `rf_we` cycles. During those cycles `rf_idx` runs 0,1,…,NREG-1 and `rf_wdata` carries sign 0, exponent all ones and mantissa all ones. The restore also sets `fresh_flag`.
- R7: A restore of a non-empty frame clears `fresh_flag` and produces no `ctl_clr` or `rf_we`.
- R8: A postincrement restore returns A+4 plus a skip chosen by bits 23:16 of the header: 24 for 8'h18, 56 for 8'h38, 180 for 8'hB4, and 0 for any other value or for an empty frame.
- R9: A restore with register-indirect addressing (mode 2) returns A unchanged.
- R10: A cycle with `fp_op_issue` high clears `fresh_flag`.
- R11: Some commands use an unsupported mode: a save with a mode other than 3 or 4, or a restore with a mode other than 2 or 3. Such a command makes no memory request, ends with `done_err`=1 and result A, and leaves `fresh_flag` unchanged.
- R12: A command is accepted only while `cmd_ready` is high, and `cmd_ready` stays low until the command's single `done_valid` pulse. A memory request that is not accepted keeps its valid, address, write flag and data unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_restore | input | 1 | 0 = save, 1 = restore |
| cmd_mode | input | 3 | Addressing mode: 2 indirect, 3 postincrement, 4 predecrement |
| cmd_areg | input | AW | Address register value A |
| fp_op_issue | input | 1 | An arithmetic or move operation was issued to the unit |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Command had an unsupported mode |
| done_areg | output | AW | Updated address register value |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the longword |
| mem_req_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ctl_clr | output | 1 | Clear control, status and instruction-address registers |
| rf_we | output | 1 | Data-register file write strobe |
| rf_idx | output | $clog2(NREG) | Data register being written |
| rf_wdata | output | 1+EXP_W+MAN_W | Power-on value for the data register |
| fresh_flag | output | 1 | Just-reset state |

## Verification
Most internal faults surface on the very next command. A stuck or wrongly updated fresh flag changes the length of the next save from one to seven writes, or the reverse. This shows at `mem_req_addr` within a few cycles of acceptance and in the returned address. A wrong format-byte decode or beat counter shows only in `done_areg` or in the write sequence of that command. A fault in the register-file walk appears as a missing or out-of-order `rf_idx` during the NREG cycles after the header arrives. A handshake fault shows as a request that changes while stalled or as a second completion pulse, both visible within one cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RDREQ,
    S_RDWAIT,
    S_FILL,
    S_DONE
  } fsr_state_e;

  // addressing mode codes on cmd_mode
  localparam logic [2:0] AM_IND  = 3'd2;
  localparam logic [2:0] AM_POST = 3'd3;
  localparam logic [2:0] AM_PRE  = 3'd4;

  // idle frame words
  localparam logic [31:0] IDLE_HEAD = 32'h1F18_0000;
  localparam logic [31:0] IDLE_TAIL = 32'h7000_0000;
  localparam int          IDLE_BEATS = 7;
  localparam int          EMPTY_BEATS = 1;
  localparam int          WORD_BYTES = 4;

  // frame format codes and the bytes skipped beyond the header
  localparam logic [7:0] FMT_IDLE  = 8'h18;
  localparam logic [7:0] FMT_UNIMP = 8'h38;
  localparam logic [7:0] FMT_BUSY  = 8'hB4;
  localparam int         SKIP_IDLE  = 24;
  localparam int         SKIP_UNIMP = 56;
  localparam int         SKIP_BUSY  = 180;

  localparam int BEAT_W = $clog2(IDLE_BEATS + 1);

endpackage

// File: rtl/fsr_addr_calc.sv
module fsr_addr_calc
  import fsr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              is_restore,
  input  logic [2:0]        mode,
  input  logic              fresh,
  input  logic [AW-1:0]     areg,
  output logic              mode_ok,
  output logic [AW-1:0]     base_addr,
  output logic [AW-1:0]     fin_addr,
  output logic [BEAT_W-1:0] beats
);

  logic [AW-1:0] span;

  always_comb begin
    mode_ok   = 1'b0;
    base_addr = areg;
    fin_addr  = areg;
    beats     = BEAT_W'(EMPTY_BEATS);
    span      = '0;
    if (is_restore) begin
      // restore: one header read at A, postincrement steps past it
      mode_ok = (mode == AM_IND) || (mode == AM_POST);
      if (mode == AM_POST) fin_addr = areg + AW'(WORD_BYTES);
    end else begin
      mode_ok = (mode == AM_POST) || (mode == AM_PRE);
      beats   = fresh ? BEAT_W'(EMPTY_BEATS) : BEAT_W'(IDLE_BEATS);
      span    = AW'(beats) * AW'(WORD_BYTES);
      if (mode == AM_POST) begin
        base_addr = areg;
        fin_addr  = areg + span;
      end else begin
        base_addr = areg - span;
        fin_addr  = areg - span;
      end
    end
  end

endmodule

// File: rtl/fsr_fmt_skip.sv
module fsr_fmt_skip
  import fsr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   hdr,
  output logic          is_empty,
  output logic [AW-1:0] skip
);

  assign is_empty = (hdr[31:24] == 8'h00);

  always_comb begin
    if (is_empty) begin
      skip = '0;
    end else begin
      unique case (hdr[23:16])
        FMT_IDLE:  skip = AW'(SKIP_IDLE);
        FMT_UNIMP: skip = AW'(SKIP_UNIMP);
        FMT_BUSY:  skip = AW'(SKIP_BUSY);
        default:   skip = '0;
      endcase
    end
  end

endmodule

// File: rtl/fsr_rf_fill.sv
module fsr_rf_fill #(
  parameter int NREG = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          we,
  output logic [IW-1:0] idx,
  output logic          first,
  output logic          last
);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (!last)     cnt_q <= cnt_q + IW'(1);
  end

  assign we    = run;
  assign idx   = cnt_q;
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == IW'(NREG - 1));

  // R6: the walk advances by one register per cycle without gaps
  p_fill_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !last) |=> (we && idx == $past(idx) + IW'(1)));

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int RW = 1 + EXP_W + MAN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_restore,
  input  logic [2:0]    cmd_mode,
  input  logic [AW-1:0] cmd_areg,
  input  logic          fp_op_issue,
  output logic          done_valid,
  output logic          done_err,
  output logic [AW-1:0] done_areg,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          ctl_clr,
  output logic          rf_we,
  output logic [IW-1:0] rf_idx,
  output logic [RW-1:0] rf_wdata,
  output logic          fresh_flag
);

  fsr_state_e        st_q;
  logic              fresh_q, err_q, post_q;
  logic [AW-1:0]     addr_q, fin_q;
  logic [BEAT_W-1:0] beat_q, nbeat_q;

  logic              accept, req_hs, hdr_in;
  logic              calc_ok;
  logic [AW-1:0]     calc_base, calc_fin;
  logic [BEAT_W-1:0] calc_beats;
  logic              hdr_empty;
  logic [AW-1:0]     hdr_skip;
  logic              fill_we, fill_first, fill_last;
  logic [IW-1:0]     fill_idx;

  fsr_addr_calc #(.AW(AW)) u_addr (
    .is_restore (cmd_restore),
    .mode       (cmd_mode),
    .fresh      (fresh_q),
    .areg       (cmd_areg),
    .mode_ok    (calc_ok),
    .base_addr  (calc_base),
    .fin_addr   (calc_fin),
    .beats      (calc_beats)
  );

  fsr_fmt_skip #(.AW(AW)) u_fmt (
    .hdr      (mem_rdata),
    .is_empty (hdr_empty),
    .skip     (hdr_skip)
  );

  fsr_rf_fill #(.NREG(NREG)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == S_FILL),
    .we    (fill_we),
    .idx   (fill_idx),
    .first (fill_first),
    .last  (fill_last)
  );

  assign cmd_ready     = (st_q == S_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign mem_req_valid = (st_q == S_WR) || (st_q == S_RDREQ);
  assign mem_req_we    = (st_q == S_WR);
  assign mem_req_addr  = addr_q;
  assign req_hs        = mem_req_valid && mem_req_ready;
  assign hdr_in        = (st_q == S_RDWAIT) && mem_rvalid;

  always_comb begin
    mem_req_wdata = 32'h0;
    if (st_q == S_WR && nbeat_q != BEAT_W'(EMPTY_BEATS)) begin
      if (beat_q == '0)                         mem_req_wdata = IDLE_HEAD;
      else if (beat_q == nbeat_q - BEAT_W'(1))  mem_req_wdata = IDLE_TAIL;
    end
  end

  assign done_valid = (st_q == S_DONE);
  assign done_err   = err_q;
  assign done_areg  = fin_q;
  assign ctl_clr    = fill_we && fill_first;
  assign rf_we      = fill_we;
  assign rf_idx     = fill_idx;
  assign rf_wdata   = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
  assign fresh_flag = fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      err_q   <= 1'b0;
      post_q  <= 1'b0;
      addr_q  <= '0;
      fin_q   <= '0;
      beat_q  <= '0;
      nbeat_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          err_q   <= !calc_ok;
          fin_q   <= calc_ok ? calc_fin : cmd_areg;
          addr_q  <= calc_base;
          nbeat_q <= calc_beats;
          beat_q  <= '0;
          post_q  <= (cmd_mode == AM_POST);
          if (!calc_ok)        st_q <= S_DONE;
          else if (cmd_restore) st_q <= S_RDREQ;
          else                  st_q <= S_WR;
        end
        S_WR: if (req_hs) begin
          addr_q <= addr_q + AW'(WORD_BYTES);
          beat_q <= beat_q + BEAT_W'(1);
          if (beat_q == nbeat_q - BEAT_W'(1)) st_q <= S_DONE;
        end
        S_RDREQ: if (req_hs) st_q <= S_RDWAIT;
        S_RDWAIT: if (mem_rvalid) begin
          if (hdr_empty) begin
            st_q <= S_FILL;
          end else begin
            if (post_q) fin_q <= fin_q + hdr_skip;
            st_q <= S_DONE;
          end
        end
        S_FILL: if (fill_last) st_q <= S_DONE;
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           fresh_q <= 1'b1;
    else if (hdr_in)      fresh_q <= hdr_empty;
    else if (fp_op_issue) fresh_q <= 1'b0;
  end

  // R12: a stalled request holds its contents
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R12: completion is a single pulse, followed by idle
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && cmd_ready));

  // R11: a bad mode goes straight to an error completion without memory traffic
  p_bad_mode_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !calc_ok) |=> (!mem_req_valid && done_valid && done_err));

  // R6: an empty header starts the clear and sets the flag
  p_empty_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && hdr_empty) |=> (fresh_flag && rf_we && ctl_clr));

  // R7: a non-empty header clears the flag and completes
  p_full_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && !hdr_empty) |=> (!fresh_flag && done_valid && !rf_we));

  // R10: an issued operation clears the flag
  p_issue_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_op_issue && !hdr_in) |=> !fresh_flag);

  // R9: indirect restore keeps the address register
  p_ind_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_restore && cmd_mode == AM_IND) |=> (done_areg == $past(cmd_areg)));

endmodule

// File: tb/sim_fsr_ctrl.sv
module sim_fsr_ctrl;
  localparam int CLK_P = 10;
  localparam logic [79:0] RF_EXP = {1'b0, 15'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready, cmd_restore = 1'b0;
  logic [2:0]  cmd_mode = 3'd0;
  logic [31:0] cmd_areg = 32'h0;
  logic        fp_op_issue = 1'b0;
  logic        done_valid, done_err;
  logic [31:0] done_areg;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        ctl_clr, rf_we, fresh_flag;
  logic [2:0]  rf_idx;
  logic [79:0] rf_wdata;

  fsr_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_restore(cmd_restore),
    .cmd_mode(cmd_mode), .cmd_areg(cmd_areg), .fp_op_issue(fp_op_issue),
    .done_valid(done_valid), .done_err(done_err), .done_areg(done_areg),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ctl_clr(ctl_clr), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .fresh_flag(fresh_flag)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] wr_a [16];
  logic [31:0] wr_d [16];
  int wr_cnt = 0, rd_cnt = 0, clr_cnt = 0, rfw_cnt = 0, rf_bad = 0, done_cnt = 0;
  logic [31:0] rd_a = 32'h0, got_fin = 32'h0, hdr_q = 32'h0;
  logic got_err = 1'b0;
  bit rd_pend = 1'b0;
  bit m_fresh = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] skip_of(input logic [7:0] f);
    case (f)
      8'h18:   return 32'd24;
      8'h38:   return 32'd56;
      8'hB4:   return 32'd180;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] frame_word(input int i, input int n);
    if (n == 1)     return 32'h0;
    if (i == 0)     return 32'h1F18_0000;
    if (i == n - 1) return 32'h7000_0000;
    return 32'h0;
  endfunction

  // memory model and port monitor, one pass per cycle at the falling edge
  initial begin
    mem_req_ready = 1'b0;
    mem_rvalid = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      mem_req_ready = ($urandom_range(3) != 0);
      if (rd_pend) begin
        mem_rvalid = 1'b1; mem_rdata = hdr_q; rd_pend = 1'b0;
      end else begin
        mem_rvalid = 1'b0; mem_rdata = $urandom;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (wr_cnt < 16) begin
            wr_a[wr_cnt] = mem_req_addr;
            wr_d[wr_cnt] = mem_req_wdata;
          end
          wr_cnt++;
        end else begin
          rd_a = mem_req_addr;
          rd_cnt++;
          rd_pend = 1'b1;
        end
      end
      if (rf_we) begin
        if (rf_idx != 3'(rfw_cnt) || rf_wdata != RF_EXP) rf_bad++;
        rfw_cnt++;
      end
      if (ctl_clr) begin
        clr_cnt++;
        if (rfw_cnt != 1) rf_bad++;
      end
      if (done_valid) begin
        got_err = done_err; got_fin = done_areg; done_cnt++;
      end
    end
  end

  task automatic issue_op();
    @(negedge clk); fp_op_issue = 1'b1;
    @(negedge clk); fp_op_issue = 1'b0;
    @(negedge clk);
    m_fresh = 1'b0;
    chk(fresh_flag == 1'b0, "R10", "fresh after issue", 32'(fresh_flag), 32'h0);
  endtask

  task automatic run_cmd(input bit rs, input logic [2:0] mode,
                         input logic [31:0] a, input logic [31:0] hdr);
    int start, n;
    bit ok, empty;
    logic [31:0] base, fin;
    ok = rs ? (mode == 3'd2 || mode == 3'd3) : (mode == 3'd3 || mode == 3'd4);
    wr_cnt = 0; rd_cnt = 0; clr_cnt = 0; rfw_cnt = 0; rf_bad = 0;
    hdr_q = hdr;
    start = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_restore = rs; cmd_mode = mode; cmd_areg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R12", "busy after accept", 32'(cmd_ready), 32'h0);
    n = 0;
    while (done_cnt == start && n < 2000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
    chk(done_cnt == start + 1, "R12", "done pulses", 32'(done_cnt - start), 32'd1);
    chk(cmd_ready == 1'b1, "R12", "ready after done", 32'(cmd_ready), 32'h1);
    if (!ok) begin
      chk(got_err == 1'b1, "R11", "error flag", 32'(got_err), 32'h1);
      chk(got_fin == a, "R11", "address kept", got_fin, a);
      chk(wr_cnt + rd_cnt == 0, "R11", "memory accesses", 32'(wr_cnt + rd_cnt), 32'h0);
      chk(fresh_flag == m_fresh, "R11", "fresh kept", 32'(fresh_flag), 32'(m_fresh));
    end else if (!rs) begin
      n = m_fresh ? 1 : 7;
      base = (mode == 3'd3) ? a : a - 32'(4 * n);
      fin  = (mode == 3'd3) ? a + 32'(4 * n) : a - 32'(4 * n);
      chk(got_err == 1'b0, m_fresh ? "R2" : "R3", "error flag", 32'(got_err), 32'h0);
      chk(wr_cnt == n && rd_cnt == 0, m_fresh ? "R2" : "R3", "write count",
          32'(wr_cnt), 32'(n));
      for (int i = 0; i < n && i < wr_cnt; i++) begin
        chk(wr_a[i] == base + 32'(4 * i), m_fresh ? "R2" : "R3", "write address",
            wr_a[i], base + 32'(4 * i));
        chk(wr_d[i] == frame_word(i, n), m_fresh ? "R2" : "R3", "write data",
            wr_d[i], frame_word(i, n));
      end
      chk(got_fin == fin, m_fresh ? "R2" : "R3", "final address", got_fin, fin);
      chk(fresh_flag == m_fresh, "R4", "fresh after save", 32'(fresh_flag), 32'(m_fresh));
    end else begin
      empty = (hdr[31:24] == 8'h00);
      fin = (mode == 3'd2) ? a : a + 32'd4 + (empty ? 32'd0 : skip_of(hdr[23:16]));
      chk(rd_cnt == 1 && wr_cnt == 0, "R5", "single read", 32'(rd_cnt + 16 * wr_cnt), 32'h1);
      chk(rd_a == a, "R5", "read address", rd_a, a);
      chk(got_err == 1'b0, "R5", "error flag", 32'(got_err), 32'h0);
      chk(got_fin == fin, (mode == 3'd2) ? "R9" : "R8", "final address", got_fin, fin);
      chk(clr_cnt == (empty ? 1 : 0), empty ? "R6" : "R7", "clear pulses",
          32'(clr_cnt), empty ? 32'd1 : 32'd0);
      chk(rfw_cnt == (empty ? 8 : 0), empty ? "R6" : "R7", "register writes",
          32'(rfw_cnt), empty ? 32'd8 : 32'd0);
      chk(rf_bad == 0, "R6", "register walk order and value", 32'(rf_bad), 32'h0);
      m_fresh = empty;
      chk(fresh_flag == m_fresh, empty ? "R6" : "R7", "fresh after restore",
          32'(fresh_flag), 32'(m_fresh));
    end
  endtask

  initial begin
    logic [2:0] modes [7];
    logic [7:0] fmts [4];
    logic [31:0] h;
    void'($urandom(32'd1234));
    modes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
    fmts  = '{8'h18, 8'h38, 8'hB4, 8'h55};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fresh_flag == 1'b1, "R1", "fresh at reset", 32'(fresh_flag), 32'h1);
    chk(cmd_ready == 1'b1, "R1", "ready at reset", 32'(cmd_ready), 32'h1);
    chk(!mem_req_valid && !done_valid && !rf_we && !ctl_clr, "R1", "outputs quiet",
        {28'h0, mem_req_valid, done_valid, rf_we, ctl_clr}, 32'h0);

    // directed corners
    run_cmd(1'b0, 3'd3, 32'h0000_1000, 32'h0);   // R2 postincrement empty save
    run_cmd(1'b0, 3'd4, 32'h0000_2000, 32'h0);   // R2 predecrement empty save
    issue_op();                                  // R10
    run_cmd(1'b0, 3'd3, 32'h0000_3000, 32'h0);   // R3
    run_cmd(1'b0, 3'd4, 32'h0000_4000, 32'h0);   // R3
    run_cmd(1'b1, 3'd2, 32'h0000_5000, 32'h1F18_0000); // R9, R7
    run_cmd(1'b1, 3'd3, 32'h0000_6000, 32'h1F18_0000); // R8
    run_cmd(1'b1, 3'd3, 32'h0000_6100, 32'h1F38_0000); // R8
    run_cmd(1'b1, 3'd3, 32'h0000_6200, 32'h1FB4_0000); // R8
    run_cmd(1'b1, 3'd3, 32'h0000_6300, 32'h1F55_0000); // R8 unknown format
    run_cmd(1'b1, 3'd2, 32'h0000_7000, 32'h0000_0000); // R6
    run_cmd(1'b0, 3'd3, 32'h0000_7100, 32'h0);   // R2 after empty restore
    run_cmd(1'b1, 3'd3, 32'h0000_8000, 32'h0018_0000); // R6, R8 empty postincrement
    run_cmd(1'b0, 3'd2, 32'h0000_9000, 32'h0);   // R11
    run_cmd(1'b1, 3'd4, 32'h0000_9100, 32'h0);   // R11
    run_cmd(1'b0, 3'd0, 32'h0000_9200, 32'h0);   // R11
    run_cmd(1'b1, 3'd7, 32'h0000_9300, 32'h0);   // R11

    // constrained random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(4) == 0) issue_op();
      h = $urandom;
      h[23:16] = ($urandom_range(3) == 0) ? h[23:16] : fmts[$urandom_range(3)];
      if ($urandom_range(3) == 0) h[31:24] = 8'h00;
      run_cmd(1'($urandom_range(1)), modes[$urandom_range(6)], $urandom & 32'hFFFF_FFFC, h);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule